// File: doc/BRIEF.md
# Clock-Recovery Lock Decision Controller

This block decides, once per clock of the receive word domain, whether the receive clock recovery loop should follow the incoming serial data or stay on the local reference clock. It applies two tests. The first is a frequency test. At the end of each measurement window, which spans 2^WIN_LOG2 reference-clock cycles, a counter outside this block reports how many recovered-clock cycles occurred in that window. The controller turns the gap between that count and the nominal count into a parts-per-million offset. It compares the offset against two pairs of limits. Which pair applies depends on the current lock state, so the test has hysteresis, and an offset that falls between the two limits of the active pair leaves the state as it is.

The second test watches the stream of parallel received words for a loss of signal. A long stretch of words that are entirely ones, or entirely zeros, with the same value throughout, counts as a dead line. An active-low force input overrides both tests and holds the loop on the reference clock. The data-select output is a register, so the downstream clock switch only ever sees a clean, edge-aligned change.

Top module: `cdr_lock_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, `sel_data` and `locked` are 0 (unlocked, reference selected).
- R2: When unlocked, a window with an offset below 244 ppm sets `locked`. With the default window of 32768 counts, this means |rec_cnt − 32768| ≤ 7.
- R3: When unlocked, an offset from 244 to 366 ppm (8 to 11 counts) leaves the state unchanged. An offset above 366 ppm (12 or more counts) also keeps it unlocked.
- R4: When locked, an offset below 488 ppm (15 counts or fewer) keeps it locked. An offset from 488 to 732 ppm (16 to 23 counts) leaves the state unchanged. An offset above 732 ppm (24 or more counts) clears `locked`.
- R5: `rec_cnt` is ignored in any cycle where `win_vld` is 0.
- R6: Loss of signal is flagged on the 12th consecutive valid word that is all ones (10'h3FF), or the 12th that is all zeros (10'h000), with the same value in every one of those words. Eleven such words do not flag. In bit terms, a run of 119 bits or fewer never flags, a run of 129 bits or more always flags, and a run of 120 to 128 bits may or may not flag depending on where it falls across word boundaries.
- R7: If a uniform word has the opposite value to the run before it, the run restarts at one word.
- R8: A valid word that is not uniform ends the run and clears the loss flag. Cycles with `word_vld` at 0 neither extend nor end the run.
- R9: When `force_ref_n` is 0, `sel_data` is 0 whatever the tests say. `locked` still follows the frequency test during that time.
- R10: `sel_data` equals `force_ref_n` AND the next `locked` state AND NOT loss of signal. It is a registered output and, like `locked`, it updates on the same clock edge that samples the stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive word clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| win_vld | input | 1 | Pulses for one cycle when `rec_cnt` holds a completed window result |
| rec_cnt | input | CNT_W (17) | Number of recovered-clock cycles counted over one window of 2^WIN_LOG2 reference cycles |
| word_vld | input | 1 | Marks `rx_word` as a valid received word |
| rx_word | input | WORD_W (10) | Parallel received word |
| force_ref_n | input | 1 | Active low: forces the reference clock to be selected |
| sel_data | output | 1 | 1 = recovery loop tracks the data; 0 = it tracks the reference |
| locked | output | 1 | Frequency lock state, including hysteresis |

## Verification
Every result is due exactly one clock edge after its stimulus is applied. The frequency verdict, the run-length flag and the force input all feed registers that load on the edge that samples them. The driver task applies each stimulus just after a falling edge and pushes the expected pair (`sel_data`, `locked`) into a queue. The monitor pops that entry on the following falling edge, which comes after the single rising edge the result needs. After reset is released, the bench waits out the two-stage reset synchroniser before it sends any stimulus.

// File: rtl/cdr_lock_pkg.sv
package cdr_lock_pkg;

  typedef enum logic {FREQ_UNLOCKED = 1'b0, FREQ_LOCKED = 1'b1} freq_state_e;

  typedef enum logic [1:0] {VERD_LOCK = 2'd0, VERD_UNLOCK = 2'd1, VERD_UNSURE = 2'd2} freq_verdict_e;

  // Exact comparison: offset_counts * 1e6 versus ppm * 2^win_log2
  function automatic logic ppm_below(input logic [31:0] offs, input int unsigned ppm,
                                     input int unsigned win_log2);
    return ({32'd0, offs} * 64'd1000000) < ({32'd0, ppm} << win_log2);
  endfunction

  function automatic logic ppm_above(input logic [31:0] offs, input int unsigned ppm,
                                     input int unsigned win_log2);
    return ({32'd0, offs} * 64'd1000000) > ({32'd0, ppm} << win_log2);
  endfunction

endpackage

// File: rtl/cdr_freq_judge.sv
module cdr_freq_judge
  import cdr_lock_pkg::*;
#(
  parameter int unsigned WIN_LOG2 = 15,
  parameter int unsigned CNT_W    = WIN_LOG2 + 2,
  parameter int unsigned PPM_HOLD = 488,
  parameter int unsigned PPM_DROP = 732,
  parameter int unsigned PPM_ACQ  = 244,
  parameter int unsigned PPM_REJ  = 366
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_vld,
  input  logic [CNT_W-1:0] rec_cnt,
  output logic             lock_q,
  output logic             lock_nxt
);

  localparam logic [CNT_W-1:0] NOM_CNT = CNT_W'(1) << WIN_LOG2;

  freq_state_e   state_q, state_d;
  freq_verdict_e verdict;
  logic [CNT_W-1:0] offs;
  logic [31:0]      offs32;

  always_comb begin
    offs   = (rec_cnt >= NOM_CNT) ? (rec_cnt - NOM_CNT) : (NOM_CNT - rec_cnt);
    offs32 = 32'(offs);
  end

  // Limits depend on the present state: hysteresis with an undecided band
  always_comb begin
    verdict = VERD_UNSURE;
    if (state_q == FREQ_LOCKED) begin
      if (ppm_below(offs32, PPM_HOLD, WIN_LOG2))      verdict = VERD_LOCK;
      else if (ppm_above(offs32, PPM_DROP, WIN_LOG2)) verdict = VERD_UNLOCK;
    end else begin
      if (ppm_below(offs32, PPM_ACQ, WIN_LOG2))       verdict = VERD_LOCK;
      else if (ppm_above(offs32, PPM_REJ, WIN_LOG2))  verdict = VERD_UNLOCK;
    end
  end

  always_comb begin
    state_d = state_q;
    if (win_vld) begin
      case (verdict)
        VERD_LOCK:   state_d = FREQ_LOCKED;
        VERD_UNLOCK: state_d = FREQ_UNLOCKED;
        default:     state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= FREQ_UNLOCKED;
    else if (win_vld) state_q <= state_d;
  end

  assign lock_q   = (state_q == FREQ_LOCKED);
  assign lock_nxt = (state_d == FREQ_LOCKED);

endmodule

// File: rtl/cdr_run_monitor.sv
module cdr_run_monitor #(
  parameter int unsigned WORD_W    = 10,
  parameter int unsigned RUN_WORDS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] rx_word,
  output logic              los_nxt
);

  localparam int unsigned RUN_W = $clog2(RUN_WORDS + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_WORDS);

  logic [RUN_W-1:0] run_q, run_d;
  logic             val_q, val_d;
  logic             all_one, all_zero, uniform;

  always_comb begin
    all_one  = &rx_word;
    all_zero = ~|rx_word;
    uniform  = all_one | all_zero;
  end

  always_comb begin
    run_d = run_q;
    val_d = val_q;
    if (word_vld) begin
      if (uniform) begin
        val_d = all_one;
        if ((run_q != '0) && (val_q == all_one))
          run_d = (run_q == RUN_MAX) ? run_q : run_q + RUN_W'(1);
        else
          run_d = RUN_W'(1);
      end else begin
        run_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      val_q <= 1'b0;
    end else if (word_vld) begin
      run_q <= run_d;
      val_q <= val_d;
    end
  end

  assign los_nxt = (run_d == RUN_MAX);

endmodule

// File: rtl/cdr_lock_ctrl.sv
module cdr_lock_ctrl #(
  parameter int unsigned WIN_LOG2  = 15,
  parameter int unsigned CNT_W     = WIN_LOG2 + 2,
  parameter int unsigned WORD_W    = 10,
  parameter int unsigned RUN_WORDS = 12,
  parameter int unsigned PPM_HOLD  = 488,
  parameter int unsigned PPM_DROP  = 732,
  parameter int unsigned PPM_ACQ   = 244,
  parameter int unsigned PPM_REJ   = 366
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_vld,
  input  logic [CNT_W-1:0]  rec_cnt,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              force_ref_n,
  output logic              sel_data,
  output logic              locked
);

  logic [1:0] rst_pipe;
  logic       rst_q;
  logic       lock_q, lock_nxt, los_nxt;
  logic       sel_q, sel_d;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  cdr_freq_judge #(
    .WIN_LOG2(WIN_LOG2), .CNT_W(CNT_W),
    .PPM_HOLD(PPM_HOLD), .PPM_DROP(PPM_DROP),
    .PPM_ACQ(PPM_ACQ),   .PPM_REJ(PPM_REJ)
  ) u_freq (
    .clk(clk), .rst_n(rst_q), .win_vld(win_vld), .rec_cnt(rec_cnt),
    .lock_q(lock_q), .lock_nxt(lock_nxt)
  );

  cdr_run_monitor #(.WORD_W(WORD_W), .RUN_WORDS(RUN_WORDS)) u_run (
    .clk(clk), .rst_n(rst_q), .word_vld(word_vld), .rx_word(rx_word),
    .los_nxt(los_nxt)
  );

  // Registered select: the clock switch sees one clean edge-aligned change
  always_comb sel_d = force_ref_n & lock_nxt & ~los_nxt;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) sel_q <= 1'b0;
    else        sel_q <= sel_d;
  end

  assign sel_data = sel_q;
  assign locked   = lock_q;

endmodule

// File: rtl/cdr_lock_chk.sv
module cdr_lock_chk #(
  parameter int unsigned WIN_LOG2 = 15,
  parameter int unsigned CNT_W    = WIN_LOG2 + 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             win_vld,
  input logic [CNT_W-1:0] rec_cnt,
  input logic             force_ref_n,
  input logic             sel_data,
  input logic             locked
);

  localparam longint NOM      = longint'(1) << WIN_LOG2;
  localparam int unsigned ACQ_MAX  = int'((244 * NOM) / 1000000);
  localparam int unsigned REJ_MIN  = int'((366 * NOM + 999999) / 1000000);
  localparam int unsigned DROP_MIN = int'((732 * NOM + 999999) / 1000000);
  localparam logic [CNT_W-1:0] NOMV = CNT_W'(NOM);

  logic [CNT_W-1:0] gap;
  logic [31:0]      gap32;
  always_comb begin
    gap   = (rec_cnt > NOMV) ? rec_cnt - NOMV : NOMV - rec_cnt;
    gap32 = 32'(gap);
  end

  // R2
  acquire_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vld && !locked && gap32 <= ACQ_MAX) |=> locked);

  // R3
  stay_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vld && !locked && gap32 >= REJ_MIN) |=> !locked);

  // R4
  drop_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vld && locked && gap32 >= DROP_MIN) |=> !locked);

  // R5
  idle_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_vld |=> $stable(locked));

  // R9
  forced_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !force_ref_n |=> !sel_data);

  // R10
  sel_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_data |-> locked);

endmodule

bind cdr_lock_ctrl cdr_lock_chk #(.WIN_LOG2(WIN_LOG2), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_q), .win_vld(win_vld), .rec_cnt(rec_cnt),
  .force_ref_n(force_ref_n), .sel_data(sel_data), .locked(locked)
);

// File: tb/tb_cdr_lock_ctrl.sv
`timescale 1ns/1ps
module tb_cdr_lock_ctrl;
  localparam int WIN_LOG2 = 15;
  localparam int CNT_W    = 17;
  localparam int WORD_W   = 10;
  localparam int NOM      = 1 << WIN_LOG2;
  localparam logic [9:0] NU   = 10'b0101010101;
  localparam logic [9:0] ONES = 10'h3FF;
  localparam logic [9:0] ZERS = 10'h000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n;
  logic              win_vld;
  logic [CNT_W-1:0]  rec_cnt;
  logic              word_vld;
  logic [WORD_W-1:0] rx_word;
  logic              force_ref_n;
  logic              sel_data;
  logic              locked;

  cdr_lock_ctrl dut (
    .clk(clk), .rst_n(rst_n), .win_vld(win_vld), .rec_cnt(rec_cnt),
    .word_vld(word_vld), .rx_word(rx_word), .force_ref_n(force_ref_n),
    .sel_data(sel_data), .locked(locked)
  );

  int checks = 0;
  int errors = 0;
  logic  q_sel[$];
  logic  q_lock[$];
  string q_req[$];
  bit    done = 0;

  task automatic compare(input logic es, input logic el, input string req);
    checks++;
    if (sel_data !== es || locked !== el) begin
      errors++;
      $display("FAIL %s: sel_data=%b locked=%b expected sel_data=%b locked=%b",
               req, sel_data, locked, es, el);
    end
  endtask

  // Monitor: pops the item pushed one cycle earlier
  always @(negedge clk) begin
    if (q_sel.size() > 0) begin
      logic  es, el;
      string r;
      es = q_sel.pop_front();
      el = q_lock.pop_front();
      r  = q_req.pop_front();
      compare(es, el, r);
    end
  end

  // Driver: apply stimulus after a falling edge and queue the expected result
  task automatic step(input logic wv, input int offs, input logic wdv, input logic [9:0] w,
                      input logic fn, input logic es, input logic el, input string req);
    @(negedge clk);
    #1;
    win_vld     = wv;
    rec_cnt     = CNT_W'(NOM + offs);
    word_vld    = wdv;
    rx_word     = w;
    force_ref_n = fn;
    q_sel.push_back(es);
    q_lock.push_back(el);
    q_req.push_back(req);
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; win_vld = 1'b0; rec_cnt = CNT_W'(NOM);
    word_vld = 1'b1; rx_word = NU; force_ref_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare(1'b0, 1'b0, "R1 during reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare(1'b0, 1'b0, "R1 after release");

    step(0, 0, 1, NU, 1, 0, 0, "R1 idle");
    step(1, 8, 1, NU, 1, 0, 0, "R3 unlocked +8 undecided");
    step(1, -12, 1, NU, 1, 0, 0, "R3 unlocked -12 stays");
    step(1, -200, 1, NU, 1, 0, 0, "R3 unlocked -200 stays");
    step(0, 0, 1, NU, 1, 0, 0, "R5 no window, zero offset");
    step(1, -7, 1, NU, 1, 1, 1, "R2 acquire at -7");
    step(1, 15, 1, NU, 1, 1, 1, "R4 locked +15 holds");
    step(1, 20, 1, NU, 1, 1, 1, "R4 locked +20 undecided");
    step(1, -23, 1, NU, 1, 1, 1, "R4 locked -23 undecided");
    step(0, 5000, 1, NU, 1, 1, 1, "R5 no window, huge offset");
    step(0, 0, 1, NU, 0, 0, 1, "R9 force low");
    step(1, 0, 1, NU, 0, 0, 1, "R9 force low, good window");
    step(1, 30, 1, NU, 0, 0, 0, "R9 lock tracks while forced");
    step(1, 0, 1, NU, 1, 1, 1, "R9 release force, R2 reacquire");

    for (int i = 0; i < 11; i++) step(0, 0, 1, ONES, 1, 1, 1, "R6 ones run below limit");
    step(0, 0, 1, ONES, 1, 0, 1, "R6 12th ones word flags");
    step(0, 0, 1, ONES, 1, 0, 1, "R6 flag held");
    step(0, 0, 1, NU, 1, 1, 1, "R8 mixed word clears");

    for (int i = 0; i < 12; i++)
      step(0, 0, 1, (i % 2 == 0) ? ONES : ZERS, 1, 1, 1, "R7 alternating values");
    step(0, 0, 1, NU, 1, 1, 1, "R8 mixed word");

    for (int i = 0; i < 11; i++) step(0, 0, 1, ZERS, 1, 1, 1, "R6 zeros run below limit");
    for (int i = 0; i < 3; i++) step(0, 0, 0, ONES, 1, 1, 1, "R8 invalid word ignored");
    step(0, 0, 1, ZERS, 1, 0, 1, "R8 run kept across invalid words, R6 flags");
    step(0, 0, 1, ONES, 1, 1, 1, "R7 value change restarts");
    step(0, 0, 1, NU, 1, 1, 1, "R8 mixed word");

    step(1, 24, 1, NU, 1, 0, 0, "R4 locked +24 drops");
    step(1, 11, 1, NU, 1, 0, 0, "R3 unlocked +11 undecided");
    step(1, 0, 1, NU, 1, 1, 1, "R2 acquire at 0");
    step(1, -30, 1, NU, 1, 0, 0, "R4 locked -30 drops");

    for (int i = 0; i < 12; i++) step(0, 0, 1, ONES, 1, 0, 0, "R10 run while unlocked");
    step(1, 3, 1, ONES, 1, 0, 1, "R10 locked but loss holds select low");
    step(0, 0, 1, NU, 1, 1, 1, "R10 loss clears, select rises");

    step(0, 0, 1, NU, 1, 1, 1, "R10 steady");
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule